// File: doc/BRIEF.md
# Pseudorandom-Walk Memory Checksum Engine

This engine produces a 64-bit attestation checksum over a 16 KB byte-addressed code memory. It does not read the memory in address order. A challenge seed keys an RC4 keystream generator, and each keystream byte, joined with one byte of the running checksum, picks the next location to read. Because the read order depends on both the seed and the data already folded in, code on a tampered device cannot know in advance which bytes will be requested.

A run begins with a one-cycle start pulse, which latches the seed and the iteration count. The engine first mixes a 256-entry permutation with the seed, one step per cycle. It then performs the requested number of fetch/fold iterations, two cycles each, against a synchronous read port. When the run ends, the engine raises a done flag. At that point it presents the eight checksum bytes and the number of cycles the run took. That cycle count depends only on the iteration count, so a verifier can compare it against an expected time budget.

Top module: `memwalk_top`

## Requirements
- R1: After synchronous reset, `done` and `mem_rd_en` are 0 and `checksum` is all zeros.
- R2: A start pulse in the idle or done state latches `seed` and `iterations`. It then runs a 256-step RC4 key schedule over an identity permutation, in which step n uses key byte `seed[8*(n mod 8)+7 : 8*(n mod 8)]`.
- R3: Each iteration draws exactly one new byte from the standard RC4 output stage, continuing from the state the key schedule left.
- R4: Each iteration makes exactly one read, with `mem_rd_en` high for one cycle. The 16-bit address is {keystream byte, C[(j-1) mod 8]}, and only its low 14 bits drive `mem_rd_addr`. Read data is taken on the cycle after `mem_rd_en`.
- R5: The fold sets C[j] to (C[j] + ((data XOR C[(j-2) mod 8]) + previous keystream byte)) mod 256, then rotates C[j] left by one bit.
- R6: At start, C is zero, j is 0 and the previous keystream byte is 0. After each iteration, j advances by one modulo 8. Byte C[k] appears on `checksum[8k+7:8k]`.
- R7: Exactly `iterations` reads occur in a run. A count of zero performs no reads and returns an all-zero checksum.
- R8: `done` rises when the run completes and stays high until the next start. At that point `run_cycles` equals 256 + 2 × `iterations`.
- R9: A start pulse during a run is ignored, and the run completes with the result and cycle count of the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request |
| seed | input | 64 | Challenge value, eight key bytes |
| iterations | input | 16 | Number of fetch/fold iterations |
| mem_rd_en | output | 1 | Read strobe to checked memory |
| mem_rd_addr | output | 14 | Read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | Run complete, result valid |
| checksum | output | 64 | Checksum vector C[7..0] |
| run_cycles | output | 18 | Cycles from start to completion |

## Verification
The main function is tried with several seeds and with iteration counts of 1, 2, 7, 8, 9 and 300. A count of 1 isolates the first fold, where the previous keystream byte is zero. Counts of 7, 8 and 9 separate the cases where j stops short of, lands on, or wraps past the end of the vector. The longer run exposes any error in how the keystream chains over time. Further runs cover a zero count, a start issued mid-run, a single flipped memory byte that the run reads, and a check that done stays held. Each is compared against an independent RC4 and checksum model.

// File: rtl/memwalk_pkg.sv
package memwalk_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KSA,
        ST_FETCH,
        ST_FOLD,
        ST_DONE
    } walk_state_t;

    typedef struct packed {
        byte_t      ks_cur;
        byte_t      ks_prev;
        logic [2:0] idx;
    } fold_ctx_t;

    localparam int KSA_STEPS = 256;
    localparam int VEC_BYTES = 8;

    function automatic byte_t rotl1(input byte_t v);
        return {v[6:0], v[7]};
    endfunction
endpackage

// File: rtl/memwalk_keystream.sv
module memwalk_keystream
    import memwalk_pkg::*;
#(
    parameter int KEY_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   init,
    input  logic                   ksa_step,
    input  logic                   prga_step,
    input  logic [8*KEY_BYTES-1:0] key,
    output byte_t                  ks_out,
    output logic                   ksa_last
);
    localparam int KI_W = $clog2(KEY_BYTES);

    byte_t sbox [KSA_STEPS];
    byte_t ii, jj;

    byte_t key_b, kj;
    byte_t pi, pj, si, sj, tsum;

    always_comb begin
        key_b = key[8*ii[KI_W-1:0] +: 8];
        kj    = jj + sbox[ii] + key_b;
        pi    = ii + 8'd1;
        pj    = jj + sbox[pi];
        si    = sbox[pi];
        sj    = sbox[pj];
        tsum  = si + sj;
        if (tsum == pi)      ks_out = sj;
        else if (tsum == pj) ks_out = si;
        else                 ks_out = sbox[tsum];
    end

    assign ksa_last = (ii == 8'hFF);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            for (int k = 0; k < KSA_STEPS; k++) sbox[k] <= 8'(k);
            ii <= '0;
            jj <= '0;
        end else if (ksa_step) begin
            sbox[ii] <= sbox[kj];
            sbox[kj] <= sbox[ii];
            ii       <= ii + 8'd1;
            jj       <= ksa_last ? 8'd0 : kj;
        end else if (prga_step) begin
            sbox[pi] <= sj;
            sbox[pj] <= si;
            ii       <= pi;
            jj       <= pj;
        end
    end

    // R2
    ksa_count_chk: assert property (@(posedge clk) disable iff (rst)
        (ksa_step && !init) |=> (ii == $past(ii) + 8'd1));
endmodule

// File: rtl/memwalk_fold.sv
module memwalk_fold
    import memwalk_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fetch,
    input  logic              fold,
    input  byte_t             ks_in,
    input  byte_t             rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       sum_vec
);
    byte_t     cvec [VEC_BYTES];
    fold_ctx_t ctx;

    logic [2:0]  idx_m1, idx_m2;
    logic [15:0] full_addr;
    byte_t       mixed, acc;

    always_comb begin
        idx_m1    = ctx.idx - 3'd1;
        idx_m2    = ctx.idx - 3'd2;
        full_addr = {ks_in, cvec[idx_m1]};
        mixed     = (rd_data ^ cvec[idx_m2]) + ctx.ks_prev;
        acc       = cvec[ctx.idx] + mixed;
    end

    assign rd_addr = full_addr[ADDR_W-1:0];

    for (genvar k = 0; k < VEC_BYTES; k++) begin : g_out
        assign sum_vec[8*k +: 8] = cvec[k];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int k = 0; k < VEC_BYTES; k++) cvec[k] <= '0;
            ctx <= '0;
        end else begin
            if (fetch) ctx.ks_cur <= ks_in;
            if (fold) begin
                cvec[ctx.idx] <= rotl1(acc);
                ctx.ks_prev   <= ctx.ks_cur;
                ctx.idx       <= ctx.idx + 3'd1;
            end
        end
    end

    // R6
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fold && !clear) |=> (ctx.idx == $past(ctx.idx) + 3'd1));
endmodule

// File: rtl/memwalk_top.sv
module memwalk_top
    import memwalk_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int ITER_W    = 16,
    parameter int KEY_BYTES = 8,
    localparam int CYC_W    = ITER_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [8*KEY_BYTES-1:0] seed,
    input  logic [ITER_W-1:0]      iterations,
    output logic                   mem_rd_en,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    input  logic [7:0]             mem_rd_data,
    output logic                   done,
    output logic [63:0]            checksum,
    output logic [CYC_W-1:0]       run_cycles
);
    walk_state_t            state;
    logic [8*KEY_BYTES-1:0] seed_q;
    logic [ITER_W-1:0]      m_q, iter_q;
    logic [CYC_W-1:0]       cyc_q;
    logic                   accept, busy, ksa_last;
    byte_t                  ks;

    assign busy   = (state == ST_KSA) || (state == ST_FETCH) || (state == ST_FOLD);
    assign accept = start && !busy;

    memwalk_keystream #(.KEY_BYTES(KEY_BYTES)) u_ks (
        .clk(clk), .rst(rst), .init(accept),
        .ksa_step(state == ST_KSA), .prga_step(state == ST_FETCH),
        .key(accept ? seed : seed_q), .ks_out(ks), .ksa_last(ksa_last)
    );

    memwalk_fold #(.ADDR_W(ADDR_W)) u_fold (
        .clk(clk), .rst(rst), .clear(accept),
        .fetch(state == ST_FETCH), .fold(state == ST_FOLD),
        .ks_in(ks), .rd_data(mem_rd_data), .rd_addr(mem_rd_addr), .sum_vec(checksum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            seed_q <= '0;
            m_q    <= '0;
            iter_q <= '0;
            cyc_q  <= '0;
        end else if (accept) begin
            state  <= ST_KSA;
            seed_q <= seed;
            m_q    <= iterations;
            iter_q <= '0;
            cyc_q  <= '0;
        end else begin
            if (busy) cyc_q <= cyc_q + 1'b1;
            case (state)
                ST_KSA:   if (ksa_last) state <= (m_q == '0) ? ST_DONE : ST_FETCH;
                ST_FETCH: state <= ST_FOLD;
                ST_FOLD: begin
                    iter_q <= iter_q + 1'b1;
                    state  <= (iter_q + 1'b1 == m_q) ? ST_DONE : ST_FETCH;
                end
                default: ;
            endcase
        end
    end

    assign mem_rd_en  = (state == ST_FETCH);
    assign done       = (state == ST_DONE);
    assign run_cycles = cyc_q;

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);
    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (iter_q < m_q));
    // R8
    done_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (run_cycles == CYC_W'(KSA_STEPS) + 2 * CYC_W'(m_q)));
    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> ($stable(m_q) && $stable(seed_q)));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!done && !mem_rd_en));
endmodule

// File: tb/test_memwalk_top.sv
module test_memwalk_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [79:0] VECS [NVEC] = '{
        {64'h0123456789ABCDEF, 16'd1},
        {64'hFEDCBA9876543210, 16'd2},
        {64'h0000000000000000, 16'd7},
        {64'hA5A5A5A55A5A5A5A, 16'd8},
        {64'h1122334455667788, 16'd9},
        {64'hDEADBEEFCAFEF00D, 16'd300}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [63:0] seed = '0;
    logic [15:0] iterations = '0;
    logic        mem_rd_en;
    logic [13:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        done;
    logic [63:0] checksum;
    logic [17:0] run_cycles;

    int   n_chk = 0;
    int   n_bad = 0;
    int   reads = 0;
    bit   tamper_on = 0;
    logic [13:0] tamper_addr = '0;
    logic [13:0] first_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memwalk_top i_memwalk_top (
        .clk(clk), .rst(rst), .start(start), .seed(seed), .iterations(iterations),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done(done), .checksum(checksum), .run_cycles(run_cycles)
    );

    function automatic logic [7:0] mem_byte(input logic [13:0] a, input bit ton, input logic [13:0] ta);
        logic [7:0] b;
        b = 8'(int'(a) * 29 + (int'(a) >> 6)) ^ 8'h3C;
        if (ton && a == ta) b = b ^ 8'h80;
        return b;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem_byte(mem_rd_addr, tamper_on, tamper_addr);
            if (reads == 0) first_addr <= mem_rd_addr;
            reads <= reads + 1;
        end
    end

    function automatic logic [63:0] model(input logic [63:0] sd, input int m, input bit ton, input logic [13:0] ta);
        logic [7:0] s [256];
        logic [7:0] c [8];
        logic [7:0] i, j, t, ks, prev, d, tmp;
        logic [2:0] x;
        logic [15:0] fa;
        logic [63:0] r;
        for (int k = 0; k < 256; k++) s[k] = 8'(k);
        j = 0;
        for (int k = 0; k < 256; k++) begin
            j = j + s[k] + sd[8*(k % 8) +: 8];
            t = s[k]; s[k] = s[j]; s[j] = t;
        end
        for (int k = 0; k < 8; k++) c[k] = 0;
        i = 0; j = 0; prev = 0; x = 0;
        for (int it = 0; it < m; it++) begin
            i = i + 8'd1;
            j = j + s[i];
            t = s[i]; s[i] = s[j]; s[j] = t;
            t = s[i] + s[j];
            ks = s[t];
            fa = {ks, c[x - 3'd1]};
            d = mem_byte(fa[13:0], ton, ta);
            tmp = c[x] + ((d ^ c[x - 3'd2]) + prev);
            c[x] = {tmp[6:0], tmp[7]};
            prev = ks;
            x = x + 3'd1;
        end
        for (int k = 0; k < 8; k++) r[8*k +: 8] = c[k];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [63:0] sd, input logic [15:0] m);
        @(negedge clk);
        reads = 0;
        seed = sd; iterations = m; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int lim = 0;
        while (!done && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] exp_a;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 done", 64'(done), 64'd0);
        check("R1 rd_en", 64'(mem_rd_en), 64'd0);
        check("R1 checksum", checksum, 64'd0);

        // R2 R3 R4 R5 R6 R7 R8: table walk
        for (int v = 0; v < NVEC; v++) begin
            pulse_start(VECS[v][79:16], VECS[v][15:0]);
            wait_done();
            check("R5 checksum", checksum, model(VECS[v][79:16], int'(VECS[v][15:0]), 0, '0));
            check("R8 run_cycles", 64'(run_cycles), 64'(256 + 2 * int'(VECS[v][15:0])));
            check("R7 reads", 64'(reads), 64'(VECS[v][15:0]));
        end

        // R7 zero iterations
        pulse_start(64'h0F0F0F0F0F0F0F0F, 16'd0);
        wait_done();
        check("R7 zero checksum", checksum, 64'd0);
        check("R7 zero reads", 64'(reads), 64'd0);
        check("R8 zero cycles", 64'(run_cycles), 64'd256);

        // R8 done holds with stable result
        exp_a = checksum;
        repeat (5) @(negedge clk);
        check("R8 done held", 64'(done), 64'd1);
        check("R8 result held", checksum, exp_a);

        // R9 start mid-run ignored
        pulse_start(64'h0011223344556677, 16'd50);
        repeat (100) @(negedge clk);
        seed = 64'h8899AABBCCDDEEFF; iterations = 16'd3; start = 1;
        @(negedge clk);
        start = 0;
        wait_done();
        check("R9 checksum", checksum, model(64'h0011223344556677, 50, 0, '0));
        check("R9 run_cycles", 64'(run_cycles), 64'd356);

        // R4 R5 tamper the first location read and expect the model's answer
        pulse_start(64'h13579BDF2468ACE0, 16'd40);
        wait_done();
        exp_a = checksum;
        tamper_addr = first_addr;
        tamper_on = 1;
        pulse_start(64'h13579BDF2468ACE0, 16'd40);
        wait_done();
        check("R4 tampered", checksum, model(64'h13579BDF2468ACE0, 40, 1, tamper_addr));
        n_chk++;
        if (checksum === exp_a) begin
            n_bad++;
            $display("FAIL R5 tamper-sensitivity actual=%h expected=differs-from-%h", checksum, exp_a);
        end
        tamper_on = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule